// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is the control core of one copy channel. Software lays out a chain of descriptors in memory, each naming a source address, a destination address, a byte length, a set of flags and the address of the following descriptor. The register front end hands the block a chain head address, a completion address and three one-cycle command pulses: start, append and reset. The block then follows the chain on its own. For each descriptor it fetches the descriptor, reads the source bytes into the memory side's local staging buffer, writes them to the destination, and can optionally post a completion word. Then it moves to the next link.

Software can grow a live chain. It links a new descriptor onto the tail and issues append. The block then rereads only the next-pointer word of the most recent descriptor, and does not refetch the whole descriptor. Descriptors marked as skip entries move no data, and malformed descriptors stop the channel with a sticky error flag. Two running counters report the bytes moved and the descriptors copied.

Top module: `dchain_dma_chan`

## Requirements
- R1: After rst_n is released the channel is idle: busy=0, mem_req=0, chan_status[1:0]=3, chan_err=0, and both counters read 0. Whenever busy is 0, chan_status[1:0] reads 3.
- R2: A start pulse while idle raises busy and sets chan_status[1:0] to 0 on the next clock edge. It then issues a read of 16 bytes at chain_addr. A start pulse while busy is ignored.
- R3: The 16-byte descriptor read returns mem_rdata with len in [15:0], flags in [23:16], source in [63:32], destination in [95:64] and next in [127:96]. A data descriptor produces a read (mem_we=0) of len bytes at the source, followed by a write (mem_we=1) of len bytes at the destination.
- R4: A descriptor whose flags bit 1 is set is skipped whatever its other flags are. It causes no data read or write, and the channel goes straight to the chain decision.
- R5: When flags bit 0 is set, the data write is followed by a 4-byte write to cmpl_addr. The data of that write is the descriptor's address with bits [5:0] cleared, OR 1. Bits [31:6] of chan_status then hold that descriptor address shifted right by 6.
- R6: At the chain decision, a nonzero next pointer fetches the descriptor it points to. A zero next pointer with no pending append makes the channel idle.
- R7: An append pulse while idle raises busy and issues a 4-byte read at (last fetched descriptor address + 12), which returns the pointer in mem_rdata[31:0]. A zero pointer makes the channel idle again, and a nonzero pointer fetches that descriptor.
- R8: An append pulse while busy is remembered. When the chain then reaches a zero next pointer, the flag is cleared and the 4-byte next-pointer read of R7 is issued instead of going idle.
- R9: A non-skip descriptor with any flag other than bit 0 set sets chan_err bit 0. The channel goes idle with no data movement.
- R10: A non-skip descriptor whose len exceeds XFER_CAP (default 256) sets chan_err bit 1. The channel goes idle with no data movement. A len equal to XFER_CAP is copied normally.
- R11: Each completed data write adds len to bytes_copied and 1 to descs_done. Skipped and rejected descriptors change neither counter.
- R12: A reset pulse idles the channel on the next edge. It drops mem_req, clears busy, chan_err and any pending append, and sets chan_status[1:0] to 3.
- R13: Once raised, mem_req, mem_we, mem_addr and mem_len hold steady until the cycle in which mem_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse: walk the chain from chain_addr |
| cmd_append | input | 1 | Append pulse: reread the tail's next pointer |
| cmd_reset | input | 1 | Channel reset pulse |
| chain_addr | input | 32 | Address of the first descriptor |
| cmpl_addr | input | 32 | Target address of completion words |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Request byte address |
| mem_len | output | 16 | Request length in bytes |
| mem_wdata | output | 32 | Completion word for completion writes |
| mem_rdata | input | 128 | Read return (descriptor or pointer) |
| mem_done | input | 1 | One-cycle completion of the current request |
| busy | output | 1 | Channel is walking a chain |
| chan_status | output | 32 | {last descriptor address >> 6, 4'b0, transfer state} |
| chan_err | output | 2 | Sticky errors: bit 0 bad flags, bit 1 over-length |
| bytes_copied | output | 32 | Running byte total |
| descs_done | output | 32 | Running count of copied descriptors |

## Verification
The bench goes after the flag corners: a skip descriptor that also carries the completion flag, a stray high flag bit, a length one above the cap and one exactly at it, and a zero length. A design that got these wrong would move data for skip entries, write a completion word it should not, or reject the largest legal copy. It also grows a chain after the walk has started, and a design that sampled append only when idle would stop without rereading the tail pointer. A start pulse in mid-chain is checked to leave the request sequence untouched. A mid-copy reset is checked to drop the request at once rather than finish the pending write.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
    localparam int ADDR_W     = 32;
    localparam int LEN_W      = 16;
    localparam int FLAG_W     = 8;
    localparam int DESC_W     = 128;
    localparam int DESC_BYTES = DESC_W / 8;
    localparam int NEXT_OFS   = 12;
    localparam int PTR_BYTES  = ADDR_W / 8;
    localparam int STAT_SHIFT = 6;
    localparam int F_CMPL     = 0;
    localparam int F_SKIP     = 1;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t             next;
        addr_t             dst;
        addr_t             src;
        logic [7:0]        rsvd;
        logic [FLAG_W-1:0] flags;
        logic [LEN_W-1:0]  len;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DFETCH, ST_NFETCH, ST_RD, ST_WR, ST_CMPL
    } state_e;

    typedef enum logic [1:0] {
        DC_DATA, DC_SKIP, DC_BADFLAG, DC_TOOLONG
    } dclass_e;

    localparam logic [1:0] XS_ACTIVE = 2'd0;
    localparam logic [1:0] XS_IDLE   = 2'd3;
endpackage

// File: rtl/dchain_classify.sv
module dchain_classify
    import dchain_pkg::*;
#(
    parameter int XFER_CAP = 256
) (
    input  desc_t   desc,
    output dclass_e cls
);
    localparam logic [FLAG_W-1:0] LEGAL_MASK = FLAG_W'(1) << F_CMPL;

    always_comb begin
        if (desc.flags[F_SKIP])
            cls = DC_SKIP;
        else if ((desc.flags & ~LEGAL_MASK) != '0)
            cls = DC_BADFLAG;
        else if (32'(desc.len) > 32'(XFER_CAP))
            cls = DC_TOOLONG;
        else
            cls = DC_DATA;
    end
endmodule

// File: rtl/dchain_counters.sv
module dchain_counters
    import dchain_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int XFER_CAP = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [LEN_W-1:0] add_len,
    output logic [CNT_W-1:0] bytes_q,
    output logic [CNT_W-1:0] descs_q
);
    typedef struct packed {
        logic [CNT_W-1:0] bytes;
        logic [CNT_W-1:0] descs;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick) begin
            cnt_d.bytes = cnt_q.bytes + CNT_W'(add_len);
            cnt_d.descs = cnt_q.descs + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign bytes_q = cnt_q.bytes;
    assign descs_q = cnt_q.descs;

    // R11: descriptor count advances by at most one per cycle
    p_desc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (descs_q == $past(descs_q)) || (descs_q == $past(descs_q) + CNT_W'(1)));

    // R10: no single copy adds more than the transfer capability
    p_bytes_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bytes_q - $past(bytes_q)) <= CNT_W'(XFER_CAP));
endmodule

// File: rtl/dchain_dma_chan.sv
module dchain_dma_chan
    import dchain_pkg::*;
#(
    parameter int XFER_CAP = 256,
    parameter int CNT_W    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_start,
    input  logic                  cmd_append,
    input  logic                  cmd_reset,
    input  logic [ADDR_W-1:0]     chain_addr,
    input  logic [ADDR_W-1:0]     cmpl_addr,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LEN_W-1:0]      mem_len,
    output logic [ADDR_W-1:0]     mem_wdata,
    input  logic [DESC_W-1:0]     mem_rdata,
    input  logic                  mem_done,
    output logic                  busy,
    output logic [ADDR_W-1:0]     chan_status,
    output logic [1:0]            chan_err,
    output logic [CNT_W-1:0]      bytes_copied,
    output logic [CNT_W-1:0]      descs_done
);
    localparam int HI_W = ADDR_W - STAT_SHIFT;

    typedef struct packed {
        state_e            st;
        logic              busy;
        logic              refresh;
        addr_t             fetch_addr;
        addr_t             last_desc;
        desc_t             desc;
        logic [HI_W-1:0]   stat_hi;
        logic [1:0]        xfer;
        logic [1:0]        err;
    } ctx_t;

    ctx_t    q, d;
    desc_t   rd_desc;
    dclass_e rd_cls;
    logic    wr_tick;

    assign rd_desc = desc_t'(mem_rdata);

    dchain_classify #(.XFER_CAP(XFER_CAP)) u_classify (
        .desc (rd_desc),
        .cls  (rd_cls)
    );

    function automatic ctx_t go_idle(input ctx_t c);
        ctx_t r;
        r      = c;
        r.st   = ST_IDLE;
        r.busy = 1'b0;
        r.xfer = XS_IDLE;
        return r;
    endfunction

    function automatic ctx_t chain_step(input ctx_t c);
        ctx_t r;
        r = c;
        if (c.desc.next != '0) begin
            r.fetch_addr = c.desc.next;
            r.st         = ST_DFETCH;
        end else if (c.refresh) begin
            r.refresh = 1'b0;
            r.st      = ST_NFETCH;
        end else begin
            r = go_idle(c);
        end
        return r;
    endfunction

    always_comb begin
        d = q;
        if (q.st != ST_IDLE && mem_done) begin
            unique case (q.st)
                ST_DFETCH: begin
                    d.desc      = rd_desc;
                    d.last_desc = q.fetch_addr;
                    unique case (rd_cls)
                        DC_SKIP:    d = chain_step(d);
                        DC_BADFLAG: begin d.err[0] = 1'b1; d = go_idle(d); end
                        DC_TOOLONG: begin d.err[1] = 1'b1; d = go_idle(d); end
                        default:    d.st = ST_RD;
                    endcase
                end
                ST_NFETCH: begin
                    d.desc.next = mem_rdata[ADDR_W-1:0];
                    if (mem_rdata[ADDR_W-1:0] == '0) begin
                        d = go_idle(d);
                    end else begin
                        d.fetch_addr = mem_rdata[ADDR_W-1:0];
                        d.st         = ST_DFETCH;
                    end
                end
                ST_RD: d.st = ST_WR;
                ST_WR: begin
                    d.stat_hi = q.last_desc[ADDR_W-1:STAT_SHIFT];
                    if (q.desc.flags[F_CMPL]) d.st = ST_CMPL;
                    else                      d = chain_step(d);
                end
                ST_CMPL: d = chain_step(d);
                default: d = go_idle(d);
            endcase
        end
        if (cmd_start && q.st == ST_IDLE) begin
            d.st         = ST_DFETCH;
            d.busy       = 1'b1;
            d.xfer       = XS_ACTIVE;
            d.fetch_addr = chain_addr;
        end
        if (cmd_append) begin
            if (d.st == ST_IDLE) begin
                d.st   = ST_NFETCH;
                d.busy = 1'b1;
                d.xfer = XS_ACTIVE;
            end else begin
                d.refresh = 1'b1;
            end
        end
        if (cmd_reset) begin
            d         = go_idle(d);
            d.refresh = 1'b0;
            d.err     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.xfer <= XS_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_req   = (q.st != ST_IDLE);
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_len   = '0;
        mem_wdata = '0;
        unique case (q.st)
            ST_DFETCH: begin
                mem_addr = q.fetch_addr;
                mem_len  = LEN_W'(DESC_BYTES);
            end
            ST_NFETCH: begin
                mem_addr = q.last_desc + ADDR_W'(NEXT_OFS);
                mem_len  = LEN_W'(PTR_BYTES);
            end
            ST_RD: begin
                mem_addr = q.desc.src;
                mem_len  = q.desc.len;
            end
            ST_WR: begin
                mem_we   = 1'b1;
                mem_addr = q.desc.dst;
                mem_len  = q.desc.len;
            end
            ST_CMPL: begin
                mem_we    = 1'b1;
                mem_addr  = cmpl_addr;
                mem_len   = LEN_W'(PTR_BYTES);
                mem_wdata = {q.stat_hi, {(STAT_SHIFT-1){1'b0}}, 1'b1};
            end
            default: ;
        endcase
    end

    assign wr_tick     = (q.st == ST_WR) && mem_done;
    assign busy        = q.busy;
    assign chan_err    = q.err;
    assign chan_status = {q.stat_hi, {(STAT_SHIFT-2){1'b0}}, q.xfer};

    dchain_counters #(.CNT_W(CNT_W), .XFER_CAP(XFER_CAP)) u_counters (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (wr_tick),
        .add_len (q.desc.len),
        .bytes_q (bytes_copied),
        .descs_q (descs_done)
    );

    // R13: an open request is held until it completes
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_done && !cmd_reset |=>
            mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_we));

    // R1: an idle channel reports the idle transfer state
    p_idle_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> chan_status[1:0] == XS_IDLE);

    // R12: a reset pulse leaves no request outstanding
    p_reset_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> !busy && !mem_req && chan_err == 2'b00);

    // R9: a newly raised error always coincides with an idle channel
    p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_err != 2'b00) && ($past(chan_err) == 2'b00) |-> !busy);

    // R5: completion words always carry the done bit and a clear low field
    p_cmpl_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_addr == cmpl_addr && q.st == ST_CMPL |->
            mem_wdata[0] && mem_wdata[STAT_SHIFT-1:1] == '0);
endmodule

// File: tb/dchain_dma_chan_tb.sv
`timescale 1ns/1ps
module dchain_dma_chan_tb;
    import dchain_pkg::*;

    localparam int LAT = 2;

    typedef struct packed {
        logic [7:0]  flags;
        logic [15:0] len;
        logic [1:0]  err;
        logic [3:0]  ntxn;
        logic [15:0] bytes;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 16'd64,  2'd0, 4'd3, 16'd64,  4'd3},
        '{8'h01, 16'd32,  2'd0, 4'd4, 16'd32,  4'd5},
        '{8'h02, 16'd100, 2'd0, 4'd1, 16'd0,   4'd4},
        '{8'h03, 16'd100, 2'd0, 4'd1, 16'd0,   4'd4},
        '{8'h04, 16'd8,   2'd1, 4'd1, 16'd0,   4'd9},
        '{8'h80, 16'd8,   2'd1, 4'd1, 16'd0,   4'd9},
        '{8'h00, 16'd257, 2'd2, 4'd1, 16'd0,   4'd10},
        '{8'h00, 16'd256, 2'd0, 4'd3, 16'd256, 4'd10},
        '{8'h00, 16'd0,   2'd0, 4'd3, 16'd0,   4'd11}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_append = 1'b0, cmd_reset = 1'b0;
    logic [31:0] chain_addr = 32'h40, cmpl_addr = 32'h300;
    logic mem_req, mem_we, mem_done = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic [15:0] mem_len;
    logic [127:0] mem_rdata = '0;
    logic busy;
    logic [31:0] chan_status, bytes_copied, descs_done;
    logic [1:0] chan_err;

    int checks = 0, fails = 0;

    logic [31:0] d_src [16], d_dst [16], d_next [16];
    logic [15:0] d_len [16];
    logic [7:0]  d_flags [16];

    int          tcount = 0;
    logic        t_we   [64];
    logic [31:0] t_addr [64], t_wd [64];
    logic [15:0] t_len  [64];

    always #4 clk = ~clk;

    dchain_dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_append(cmd_append),
        .cmd_reset(cmd_reset), .chain_addr(chain_addr), .cmpl_addr(cmpl_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done),
        .busy(busy), .chan_status(chan_status), .chan_err(chan_err),
        .bytes_copied(bytes_copied), .descs_done(descs_done)
    );

    function automatic string rtag(input int r);
        return $sformatf("R%0d", r);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // memory responder: completes each request LAT+1 cycles after it is seen
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            if (mem_done) begin
                mem_done = 1'b0;
                lat = 0;
            end else if (mem_req) begin
                if (lat == LAT) begin
                    if (!mem_we && mem_len == 16'd4) begin
                        mem_rdata = {96'h0, d_next[(mem_addr - 32'd12) >> 5 & 32'hF]};
                    end else if (!mem_we && mem_len == 16'd16) begin
                        mem_rdata = {d_next[mem_addr[8:5]], d_dst[mem_addr[8:5]],
                                     d_src[mem_addr[8:5]], 8'h00,
                                     d_flags[mem_addr[8:5]], d_len[mem_addr[8:5]]};
                    end else begin
                        mem_rdata = '0;
                    end
                    if (tcount < 64) begin
                        t_we[tcount]   = mem_we;
                        t_addr[tcount] = mem_addr;
                        t_len[tcount]  = mem_len;
                        t_wd[tcount]   = mem_wdata;
                    end
                    tcount++;
                    mem_done = 1'b1;
                    lat = 0;
                end else begin
                    lat++;
                end
            end else begin
                lat = 0;
            end
        end
    end

    task automatic set_desc(input int idx, input logic [7:0] fl, input logic [15:0] ln,
                            input logic [31:0] nx);
        d_flags[idx] = fl;
        d_len[idx]   = ln;
        d_src[idx]   = 32'h1000;
        d_dst[idx]   = 32'h2000;
        d_next[idx]  = nx;
    endtask

    task automatic pulse_start(input logic [31:0] a);
        chain_addr = a;
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic pulse_append();
        @(negedge clk); cmd_append = 1'b1;
        @(negedge clk); cmd_append = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk); cmd_reset = 1'b1;
        @(negedge clk); cmd_reset = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL R13: watchdog expired, actual busy %0b expected 0", busy);
        finish_run();
    end

    initial begin
        logic [31:0] b0, n0;
        for (int i = 0; i < 16; i++) set_desc(i, 8'h00, 16'd0, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1 status", {30'b0, chan_status[1:0]}, 32'd3);
        chk("R1 err", {30'b0, chan_err}, 32'd0);
        chk("R1 bytes", bytes_copied, 32'd0);
        chk("R1 descs", descs_done, 32'd0);

        // single-descriptor vectors
        for (int v = 0; v < NV; v++) begin
            pulse_reset();
            set_desc(2, VECS[v].flags, VECS[v].len, 32'h0);
            tcount = 0;
            b0 = bytes_copied;
            n0 = descs_done;
            pulse_start(32'h40);
            wait_idle();
            chk({rtag(int'(VECS[v].tag)), " txn count"}, tcount, 32'(VECS[v].ntxn));
            chk({rtag(int'(VECS[v].tag)), " err"}, {30'b0, chan_err}, 32'(VECS[v].err));
            chk("R11 bytes delta", bytes_copied - b0, 32'(VECS[v].bytes));
            chk("R11 descs delta", descs_done - n0, (VECS[v].ntxn >= 3) ? 32'd1 : 32'd0);
            chk("R2 fetch addr", t_addr[0], 32'h40);
            chk("R2 fetch len", {16'b0, t_len[0]}, 32'd16);
            chk("R1 idle status", {30'b0, chan_status[1:0]}, 32'd3);
            if (VECS[v].ntxn >= 3) begin
                chk("R3 read", {t_we[1], t_addr[1][30:0]}, 32'h1000);
                chk("R3 read len", {16'b0, t_len[1]}, 32'(VECS[v].len));
                chk("R3 write", {t_we[2], t_addr[2][30:0]}, 32'h80002000);
            end
            if (VECS[v].ntxn == 4) begin
                chk("R5 cmpl addr", t_addr[3], 32'h300);
                chk("R5 cmpl data", t_wd[3], 32'h41);
                chk("R5 status hi", chan_status, 32'h43);
            end
        end

        // chain with skip and completion; start ignored mid-chain
        pulse_reset();
        set_desc(2, 8'h00, 16'd16, 32'h80);
        set_desc(4, 8'h03, 16'd40, 32'hA0);
        set_desc(5, 8'h01, 16'd24, 32'h0);
        tcount = 0;
        pulse_start(32'h40);
        chk("R13 addr held", mem_addr, 32'h40);
        @(negedge clk);
        chk("R13 addr held 2", mem_addr, 32'h40);
        chk("R2 busy", {31'b0, busy}, 32'd1);
        chk("R2 status active", {30'b0, chan_status[1:0]}, 32'd0);
        for (int i = 0; i < 200 && tcount < 2; i++) @(negedge clk);
        pulse_start(32'h100);
        chain_addr = 32'h40;
        wait_idle();
        chk("R6 chain txns", tcount, 32'd8);
        chk("R6 second fetch", t_addr[3], 32'h80);
        chk("R4 skip then fetch", t_addr[4], 32'hA0);
        chk("R2 start ignored", t_addr[5], 32'h1000);
        chk("R5 chain cmpl", t_wd[7], 32'h81);
        chk("R5 chain status", chan_status, 32'h83);

        // append while idle
        set_desc(5, 8'h01, 16'd24, 32'hC0);
        set_desc(6, 8'h00, 16'd8, 32'h0);
        tcount = 0;
        pulse_append();
        chk("R7 busy", {31'b0, busy}, 32'd1);
        wait_idle();
        chk("R7 txns", tcount, 32'd4);
        chk("R7 ptr read", {t_addr[0][15:0], t_len[0]}, 32'h00AC0004);
        chk("R7 new fetch", t_addr[1], 32'hC0);
        tcount = 0;
        pulse_append();
        wait_idle();
        chk("R7 zero ptr", tcount, 32'd1);
        chk("R7 zero ptr addr", t_addr[0], 32'hCC);
        chk("R7 idle", {31'b0, busy}, 32'd0);

        // append while busy
        set_desc(8, 8'h00, 16'd16, 32'h0);
        set_desc(9, 8'h00, 16'd4, 32'h0);
        tcount = 0;
        pulse_start(32'h100);
        for (int i = 0; i < 200 && tcount < 1; i++) @(negedge clk);
        d_next[8] = 32'h120;
        pulse_append();
        wait_idle();
        chk("R8 txns", tcount, 32'd7);
        chk("R8 ptr reread", {t_addr[3][15:0], t_len[3]}, 32'h010C0004);
        chk("R8 appended fetch", t_addr[4], 32'h120);

        // reset mid-copy
        set_desc(2, 8'h00, 16'd64, 32'h0);
        tcount = 0;
        pulse_start(32'h40);
        for (int i = 0; i < 200 && tcount < 1; i++) @(negedge clk);
        pulse_reset();
        chk("R12 req dropped", {31'b0, mem_req}, 32'd0);
        chk("R12 busy", {31'b0, busy}, 32'd0);
        chk("R12 status", {30'b0, chan_status[1:0]}, 32'd3);
        repeat (8) @(negedge clk);
        chk("R12 no write", {31'b0, t_we[tcount-1]}, 32'd0);

        finish_run();
    end
endmodule